// File: doc/BRIEF.md
# Machine-check state snapshot register bank

This block is the register bank that backs a processor's machine-check logging. It holds three kinds of register. A read-only capability word describes the machine-check implementation. Ten state-save registers take a copy of the processor's architectural state when a machine-check exception is raised. A miscellaneous status register holds one sticky bit. That bit records a page fault or page assist that hit the debug-store engine while it was writing a branch-trace or sampling record.

Software reaches all of these through a simple register port. A read request returns data, flagged valid, on the cycle after the request. A write request returns nothing. The core drives the hard-error input and the machine-check enable input, along with its live register values. When both inputs are high in a cycle, the block takes all ten values from that same cycle on one clock edge and pulses the exception output. A debug-store fault sets the sticky bit and pulses a shutdown output. A separate output tells the debug-store engine whether it may run again.

Top module: `mc_state_bank`

## Requirements
- R1: A read of address 0x00 returns 0x0000_0000_000A_0304. This value holds the bank count 4 in bits 7:0, the global-control-present flag (1) in bit 8, the extended-state-present flag (1) in bit 9 and the extended register count 10 in bits 23:16, with every other bit 0. For any read, reg_rvalid_o is high and reg_rdata_o carries the data on the cycle after the cycle in which reg_req_i=1 and reg_we_i=0.
- R2: A write to address 0x00 leaves the capability value read back unchanged.
- R3: mce_o is high for one cycle, on the cycle after a cycle with hard_err_i=1 and mce_en_i=1. mce_o stays low after a cycle with hard_err_i=1 and mce_en_i=0.
- R4: When an exception is raised, all ten state-save registers load on one edge the values of gpr_i, flags_i and ip_i from the cycle in which the exception was raised. In any other cycle they hold, and this includes a hard error while the enable is 0.
- R5: The state-save layout starts at 0x10 and runs in this order: gpr_i[0] (EAX) at 0x10, then gpr_i[1..7] (EBX, ECX, EDX, ESI, EDI, EBP, ESP) at 0x11 to 0x17, flags at 0x18 and instruction pointer at 0x19. The miscellaneous register is at 0x1A. Each 32-bit saved value reads back zero-extended to 64 bits.
- R6: A write to a state-save address does not change the value read back.
- R7: When ds_fault_i=1, bit 0 of the miscellaneous register is set and shutdown_o pulses on the next cycle. ds_ok_o is 0 while the bit is set and 1 once it is clear. Bits 63:1 of the miscellaneous register always read 0.
- R8: The debug-store bit stays set until a write to 0x1A with reg_wdata_i[0]=0. A write with bit 0 set to 1 has no effect.
- R9: When ds_fault_i=1 in the same cycle as a clearing write, the bit ends up set.
- R10: Addresses 0x1B to 0x3A are reserved, and they read 0 and ignore writes. Any other address outside the defined ones also reads 0.
- R11: A second exception overwrites every saved value with the state from its own cycle.
- R12: After reset, all saved values and the debug-store bit are 0, mce_o, shutdown_o and reg_rvalid_o are 0, and ds_ok_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hard_err_i | input | 1 | An uncorrectable error was logged this cycle |
| mce_en_i | input | 1 | Machine-check exception enable |
| gpr_i | input | 8x32 | Live general-purpose registers, index 0..7 = EAX, EBX, ECX, EDX, ESI, EDI, EBP, ESP |
| flags_i | input | 32 | Live flags register |
| ip_i | input | 32 | Live instruction pointer |
| ds_fault_i | input | 1 | Page fault or assist during a debug-store record write |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 64 | Write data |
| reg_rvalid_o | output | 1 | Read data valid |
| reg_rdata_o | output | 64 | Read data |
| mce_o | output | 1 | Machine-check exception pulse |
| shutdown_o | output | 1 | Shutdown pulse on a debug-store fault |
| ds_ok_o | output | 1 | Debug-store engine may operate |

## Verification
Live state is driven with a new value pattern on every cycle. A snapshot taken one cycle early or late therefore gives values from a neighbouring cycle, and a snapshot that loads registers on different cycles gives a mix of cycles. A hard error with the enable at 0 is sent between two real exceptions, which separates gating from mere capture. The second exception uses a different pattern, so an overwrite can be told from a snapshot that was held. For the sticky bit, the bench tries a fault alone, a write of 1, a write of 0, and a fault that coincides with a clearing write. Together these show sticking, clearing and which of two events in the same cycle takes priority.

// File: rtl/mc_state_pkg.sv
package mc_state_pkg;

  localparam int unsigned CNT_W = 8;

  typedef enum logic [2:0] {
    RG_CAP,
    RG_SAVE,
    RG_MISC,
    RG_RSVD,
    RG_NONE
  } region_e;

  function automatic region_e classify(input int unsigned a,
                                       input int unsigned cap_a,
                                       input int unsigned base,
                                       input int unsigned nsave,
                                       input int unsigned nrsvd);
    if (a == cap_a)                                      return RG_CAP;
    if (a >= base && a < base + nsave)                   return RG_SAVE;
    if (a == base + nsave)                               return RG_MISC;
    if (a > base + nsave && a <= base + nsave + nrsvd)   return RG_RSVD;
    return RG_NONE;
  endfunction

endpackage

// File: rtl/mc_cap_gen.sv
module mc_cap_gen #(
  parameter int unsigned REG_W        = 64,
  parameter int unsigned BANK_CNT     = 4,
  parameter bit          GCTL_PRESENT = 1'b1,
  parameter bit          EXT_PRESENT  = 1'b1,
  parameter int unsigned NUM_SAVE     = 10
) (
  output logic [REG_W-1:0] cap_o
);
  import mc_state_pkg::*;

  localparam int unsigned GCTL_BIT = CNT_W;
  localparam int unsigned EXT_BIT  = CNT_W + 1;
  localparam int unsigned XCNT_LSB = 2 * CNT_W;

  logic [CNT_W-1:0] xcnt;

  generate
    if (EXT_PRESENT) begin : g_ext
      assign xcnt = CNT_W'(NUM_SAVE);
    end else begin : g_noext
      assign xcnt = '0;
    end
  endgenerate

  always_comb begin
    cap_o                            = '0;
    cap_o[CNT_W-1:0]                 = CNT_W'(BANK_CNT);
    cap_o[GCTL_BIT]                  = GCTL_PRESENT;
    cap_o[EXT_BIT]                   = EXT_PRESENT;
    cap_o[XCNT_LSB +: CNT_W]         = xcnt;
  end

endmodule

// File: rtl/mc_snapshot.sv
module mc_snapshot #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned NUM_SAVE = 10
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           capture_i,
  input  logic [NUM_SAVE-1:0][XLEN-1:0]  live_i,
  output logic [NUM_SAVE-1:0][XLEN-1:0]  save_o
);

  generate
    for (genvar k = 0; k < NUM_SAVE; k++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        save_o[k] <= '0;
        else if (capture_i) save_o[k] <= live_i[k];
      end
    end
  endgenerate

endmodule

// File: rtl/mc_misc_status.sv
module mc_misc_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic bit_o,
  output logic shutdown_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o      <= 1'b0;
      shutdown_o <= 1'b0;
    end else begin
      shutdown_o <= set_i;
      if (set_i)      bit_o <= 1'b1;   // set has priority over clear
      else if (clr_i) bit_o <= 1'b0;
    end
  end

endmodule

// File: rtl/mc_reg_port.sv
module mc_reg_port #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned REG_W     = 64,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SAVE  = 10,
  parameter int unsigned CAP_ADDR  = 0,
  parameter int unsigned SAVE_BASE = 16,
  parameter int unsigned RSVD_CNT  = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  input  logic [REG_W-1:0]              cap_i,
  input  logic [NUM_SAVE-1:0][XLEN-1:0] save_i,
  input  logic                          misc_i,
  output logic                          misc_clr_o,
  output logic                          rvalid_o,
  output logic [REG_W-1:0]              rdata_o
);
  import mc_state_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_SAVE);

  region_e          region;
  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] rd_d;
  logic             rd_go;
  logic             unused_wdata;

  assign region       = classify(32'(addr_i), CAP_ADDR, SAVE_BASE, NUM_SAVE, RSVD_CNT);
  assign idx          = IDX_W'(32'(addr_i) - SAVE_BASE);
  assign rd_go        = req_i && !we_i;
  assign misc_clr_o   = req_i && we_i && (region == RG_MISC) && !wdata_i[0];
  assign unused_wdata = ^wdata_i[REG_W-1:1];

  always_comb begin
    rd_d = '0;
    unique case (region)
      RG_CAP:  rd_d = cap_i;
      RG_SAVE: rd_d = REG_W'(save_i[idx]);
      RG_MISC: rd_d = REG_W'(misc_i);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_go;
      if (rd_go) rdata_o <= rd_d;
    end
  end

endmodule

// File: rtl/mc_state_bank.sv
module mc_state_bank #(
  parameter int unsigned XLEN         = 32,
  parameter int unsigned REG_W        = 64,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned NUM_GPR      = 8,
  parameter int unsigned BANK_CNT     = 4,
  parameter bit          GCTL_PRESENT = 1'b1,
  parameter bit          EXT_PRESENT  = 1'b1,
  parameter int unsigned CAP_ADDR     = 0,
  parameter int unsigned SAVE_BASE    = 16,
  parameter int unsigned RSVD_CNT     = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         hard_err_i,
  input  logic                         mce_en_i,
  input  logic [NUM_GPR-1:0][XLEN-1:0] gpr_i,
  input  logic [XLEN-1:0]              flags_i,
  input  logic [XLEN-1:0]              ip_i,
  input  logic                         ds_fault_i,
  input  logic                         reg_req_i,
  input  logic                         reg_we_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [REG_W-1:0]             reg_wdata_i,
  output logic                         reg_rvalid_o,
  output logic [REG_W-1:0]             reg_rdata_o,
  output logic                         mce_o,
  output logic                         shutdown_o,
  output logic                         ds_ok_o
);

  localparam int unsigned NUM_SAVE = NUM_GPR + 2;
  localparam int unsigned FLAGS_IX = NUM_GPR;
  localparam int unsigned IP_IX    = NUM_GPR + 1;

  logic [NUM_SAVE-1:0][XLEN-1:0] live;
  logic [NUM_SAVE-1:0][XLEN-1:0] save_q;
  logic [REG_W-1:0]              cap_val;
  logic                          raise;
  logic                          ds_bit_q;
  logic                          misc_clr;
  logic                          mce_q;

  generate
    for (genvar k = 0; k < NUM_GPR; k++) begin : g_live
      assign live[k] = gpr_i[k];
    end
  endgenerate
  assign live[FLAGS_IX] = flags_i;
  assign live[IP_IX]    = ip_i;

  assign raise = hard_err_i && mce_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mce_q <= 1'b0;
    else         mce_q <= raise;
  end
  assign mce_o   = mce_q;
  assign ds_ok_o = !ds_bit_q;

  mc_cap_gen #(
    .REG_W(REG_W), .BANK_CNT(BANK_CNT), .GCTL_PRESENT(GCTL_PRESENT),
    .EXT_PRESENT(EXT_PRESENT), .NUM_SAVE(NUM_SAVE)
  ) u_cap (
    .cap_o(cap_val)
  );

  mc_snapshot #(.XLEN(XLEN), .NUM_SAVE(NUM_SAVE)) u_snap (
    .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(raise),
    .live_i(live), .save_o(save_q)
  );

  mc_misc_status u_misc (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ds_fault_i), .clr_i(misc_clr),
    .bit_o(ds_bit_q), .shutdown_o(shutdown_o)
  );

  mc_reg_port #(
    .XLEN(XLEN), .REG_W(REG_W), .ADDR_W(ADDR_W), .NUM_SAVE(NUM_SAVE),
    .CAP_ADDR(CAP_ADDR), .SAVE_BASE(SAVE_BASE), .RSVD_CNT(RSVD_CNT)
  ) u_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(reg_req_i), .we_i(reg_we_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .cap_i(cap_val),
    .save_i(save_q), .misc_i(ds_bit_q), .misc_clr_o(misc_clr),
    .rvalid_o(reg_rvalid_o), .rdata_o(reg_rdata_o)
  );

endmodule

// File: rtl/mc_state_bank_chk.sv
module mc_state_bank_chk #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned REG_W     = 64,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SAVE  = 10,
  parameter int unsigned BANK_CNT  = 4,
  parameter int unsigned CAP_ADDR  = 0,
  parameter int unsigned SAVE_BASE = 16,
  parameter int unsigned RSVD_CNT  = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          hard_err_i,
  input logic                          mce_en_i,
  input logic [XLEN-1:0]               ip_i,
  input logic                          ds_fault_i,
  input logic                          reg_req_i,
  input logic                          reg_we_i,
  input logic [ADDR_W-1:0]             reg_addr_i,
  input logic [REG_W-1:0]              reg_wdata_i,
  input logic                          reg_rvalid_o,
  input logic [REG_W-1:0]              reg_rdata_o,
  input logic                          mce_o,
  input logic                          shutdown_o,
  input logic [NUM_SAVE-1:0][XLEN-1:0] save_q,
  input logic                          ds_bit_q
);

  localparam int unsigned MISC_A  = SAVE_BASE + NUM_SAVE;
  localparam logic [REG_W-1:0] EXP_CAP =
    REG_W'({8'(NUM_SAVE), 6'b0, 1'b1, 1'b1, 8'(BANK_CNT)});

  logic rd, rsvd_hit, clr_wr;
  assign rd       = reg_req_i && !reg_we_i;
  assign rsvd_hit = 32'(reg_addr_i) > MISC_A && 32'(reg_addr_i) <= MISC_A + RSVD_CNT;
  assign clr_wr   = reg_req_i && reg_we_i && 32'(reg_addr_i) == MISC_A && !reg_wdata_i[0];

  assert_cap_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && 32'(reg_addr_i) == CAP_ADDR) |=> (reg_rvalid_o && reg_rdata_o == EXP_CAP));

  assert_mce_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard_err_i && mce_en_i) |=> mce_o);

  assert_no_mce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hard_err_i && mce_en_i) |=> !mce_o);

  assert_capture_ip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard_err_i && mce_en_i) |=> save_q[NUM_SAVE-1] == $past(ip_i));

  // R6: writes never disturb the snapshot either
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hard_err_i && mce_en_i) |=> $stable(save_q));

  assert_ds_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_fault_i |=> (ds_bit_q && shutdown_o));

  assert_ds_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_bit_q && !clr_wr) |=> ds_bit_q);

  assert_rsvd_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && rsvd_hit) |=> (reg_rvalid_o && reg_rdata_o == '0));

endmodule

bind mc_state_bank mc_state_bank_chk #(
  .XLEN(XLEN), .REG_W(REG_W), .ADDR_W(ADDR_W), .NUM_SAVE(NUM_GPR + 2),
  .BANK_CNT(BANK_CNT), .CAP_ADDR(CAP_ADDR), .SAVE_BASE(SAVE_BASE), .RSVD_CNT(RSVD_CNT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hard_err_i(hard_err_i), .mce_en_i(mce_en_i),
  .ip_i(ip_i), .ds_fault_i(ds_fault_i), .reg_req_i(reg_req_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rvalid_o(reg_rvalid_o),
  .reg_rdata_o(reg_rdata_o), .mce_o(mce_o), .shutdown_o(shutdown_o),
  .save_q(save_q), .ds_bit_q(ds_bit_q)
);

// File: tb/mc_state_bank_tb.sv
module mc_state_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] CAP_EXP = 64'h0000_0000_000A_0304;
  localparam logic [7:0]  SAVE_A  = 8'h10;
  localparam logic [7:0]  MISC_A  = 8'h1A;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hard = 1'b0, en = 1'b1, fault = 1'b0;
  logic [7:0][31:0]  gpr = '0;
  logic [31:0]       flags = '0, ip = '0;
  logic              req = 1'b0, we = 1'b0;
  logic [7:0]        addr = '0;
  logic [63:0]       wdata = '0;
  logic              rvalid, mce, shut, ds_ok;
  logic [63:0]       rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_state_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hard_err_i(hard), .mce_en_i(en),
    .gpr_i(gpr), .flags_i(flags), .ip_i(ip), .ds_fault_i(fault),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rvalid_o(rvalid), .reg_rdata_o(rdata), .mce_o(mce),
    .shutdown_o(shut), .ds_ok_o(ds_ok)
  );

  function automatic logic [31:0] pat(input int s, input int k);
    return 32'(s * 65536 + k * 256 + 8'h5A);
  endfunction

  task automatic set_live(input int s);
    for (int k = 0; k < 8; k++) gpr[k] = pat(s, k);
    flags = pat(s, 8);
    ip    = pat(s, 9);
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus at a falling edge
  task automatic cyc(input logic r, input logic w, input logic [7:0] a,
                     input logic [63:0] d, input logic h, input logic f);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; hard = h; fault = f;
  endtask

  task automatic rd(input logic [7:0] a, input logic [63:0] e, input string tag);
    cyc(1'b1, 1'b0, a, '0, 1'b0, 1'b0);
    exp_q.push_back('{exp: e, tag: tag});
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    cyc(1'b1, 1'b1, a, d, 1'b0, 1'b0);
  endtask

  // idle cycle, then check the outputs registered from the previous cycle
  task automatic idle_chk(input logic e_mce, input logic e_sh, input logic e_ok,
                          input string tag);
    cyc(1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
    chk(64'(mce), 64'(e_mce), {tag, " mce_o"});
    chk(64'(shut), 64'(e_sh), {tag, " shutdown_o"});
    chk(64'(ds_ok), 64'(e_ok), {tag, " ds_ok_o"});
  endtask

  task automatic rd_snapshot(input int s, input string tag);
    for (int k = 0; k < 10; k++)
      rd(SAVE_A + 8'(k), {32'h0, pat(s, k)}, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected rvalid actual=%h expected=none", rdata);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(rdata, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_live(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(64'(rvalid), 64'd0, "R12 rvalid");
    chk(64'(mce), 64'd0, "R12 mce_o");
    chk(64'(shut), 64'd0, "R12 shutdown_o");
    chk(64'(ds_ok), 64'd1, "R12 ds_ok_o");
    for (int k = 0; k < 10; k++) rd(SAVE_A + 8'(k), 64'h0, "R12 save zero");
    rd(MISC_A, 64'h0, "R12 misc zero");

    // R1, R2 capability
    rd(8'h00, CAP_EXP, "R1 cap");
    wr(8'h00, '1);
    rd(8'h00, CAP_EXP, "R2 cap after write");

    // R3, R4, R5: live state changes every cycle
    set_live(2);
    cyc(1'b0, 1'b0, '0, '0, 1'b0, 1'b0); set_live(3);
    cyc(1'b0, 1'b0, '0, '0, 1'b1, 1'b0);   // raise with seed 3
    @(posedge clk); #1 set_live(4);
    idle_chk(1'b1, 1'b0, 1'b1, "R3 raise");
    set_live(5);
    idle_chk(1'b0, 1'b0, 1'b1, "R3 one-cycle pulse");
    rd_snapshot(3, "R4 R5 snapshot same cycle");

    // R3, R4 enable low
    en = 1'b0; set_live(7);
    cyc(1'b0, 1'b0, '0, '0, 1'b1, 1'b0);
    idle_chk(1'b0, 1'b0, 1'b1, "R3 enable low");
    en = 1'b1;
    rd_snapshot(3, "R4 hold when disabled");

    // R6 writes to save regs ignored
    wr(SAVE_A, '1);
    wr(SAVE_A + 8'd9, 64'h1234);
    rd(SAVE_A, {32'h0, pat(3, 0)}, "R6 save write ignored");
    rd(SAVE_A + 8'd9, {32'h0, pat(3, 9)}, "R6 ip write ignored");

    // R11 second exception overwrites
    set_live(9);
    cyc(1'b0, 1'b0, '0, '0, 1'b1, 1'b0);
    @(posedge clk); #1 set_live(10);
    idle_chk(1'b1, 1'b0, 1'b1, "R11 second raise");
    rd_snapshot(9, "R11 overwrite");

    // R7 fault sets sticky bit
    cyc(1'b0, 1'b0, '0, '0, 1'b0, 1'b1);
    idle_chk(1'b0, 1'b1, 1'b0, "R7 fault");
    idle_chk(1'b0, 1'b0, 1'b0, "R7 shutdown pulse ends");
    rd(MISC_A, 64'h1, "R7 misc bit");
    // R8 write 1 no effect, write 0 clears
    wr(MISC_A, '1);
    idle_chk(1'b0, 1'b0, 1'b0, "R8 write one kept");
    rd(MISC_A, 64'h1, "R8 misc after write one");
    wr(MISC_A, 64'h0);
    idle_chk(1'b0, 1'b0, 1'b1, "R8 cleared");
    rd(MISC_A, 64'h0, "R8 misc after clear");
    // R9 set wins
    cyc(1'b1, 1'b1, MISC_A, 64'h0, 1'b0, 1'b1);
    idle_chk(1'b0, 1'b1, 1'b0, "R9 set wins");
    rd(MISC_A, 64'h1, "R9 misc set");
    wr(MISC_A, 64'hFFFF_FFFF_FFFF_FFFE);
    idle_chk(1'b0, 1'b0, 1'b1, "R8 clear bit0 zero");

    // R10 reserved and unmapped
    wr(8'h1B, '1);
    wr(8'h3A, '1);
    rd(8'h1B, 64'h0, "R10 reserved low");
    rd(8'h3A, 64'h0, "R10 reserved high");
    rd(8'h2C, 64'h0, "R10 reserved mid");
    rd(8'h3B, 64'h0, "R10 unmapped above");
    rd(8'h05, 64'h0, "R10 unmapped gap");
    rd(MISC_A, 64'h0, "R10 misc untouched");
    rd(SAVE_A + 8'd9, {32'h0, pat(9, 9)}, "R10 save untouched");

    cyc(1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(64'(exp_q.size()), 64'd0, "R1 all reads returned");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule